// File: doc/BRIEF.md
# Lockout-Window Contact Debouncer

This block turns one noisy, asynchronous mechanical contact line into a clean level that logic on the system clock (50 MHz by default) can use directly. The raw line first crosses into the clock domain through a two-flop synchroniser. The synchronised level is then compared with its value one cycle earlier. The first difference opens a lockout window of `WIN_CYCLES` clock cycles. For the rest of that window the block disregards every further edge on the line.

When the window closes, the output takes whatever synchronised level is present at that moment, and the block goes back to watching for changes. The window has to outlast the worst contact dropout, about 0.2 ms or 10,000 cycles. It also has to stay shorter than one phase of a quadrature knob, so that two debouncers on an encoder pair still show which line moved first. The default of 25,000 cycles (0.5 ms) sits between those bounds.

Control is a two-state machine. In `ST_IDLE` the block waits. The transition *arm* (a change seen on the synchronised line) moves it to `ST_HOLD`. In `ST_HOLD` the window counter runs. The transition *release* (the counter reaching its last cycle) updates the output and returns the machine to `ST_IDLE`.

Top module: `lockout_debouncer`

## Requirements
- R1: While `rst` is high at a clock edge, `clean_out`, both synchroniser flops, the previous-level register and the window counter are cleared to 0 and the machine enters `ST_IDLE`. A line held low after reset keeps `clean_out` at 0.
- R2: A change on `bouncy_in` that is first sampled at rising edge n and then held reaches `clean_out` at rising edge n+WIN_CYCLES+2, and not earlier. The +2 is the two synchroniser stages.
- R3: Once a window opens at edge n, transitions on `bouncy_in` sampled at edges n+1 through n+WIN_CYCLES-1 neither move `clean_out` nor shift the time at which the window closes.
- R4: When the window closes, `clean_out` takes the level of `bouncy_in` sampled at edge n+WIN_CYCLES. A pulse that lasts WIN_CYCLES cycles or fewer and then returns to the old level leaves `clean_out` unchanged.
- R5: After a window closes, the block re-arms. A pulse held for w > WIN_CYCLES cycles makes `clean_out` follow it for exactly w cycles, delayed by WIN_CYCLES+2.
- R6: `clean_out` changes at most once per window. Any two changes of `clean_out` are at least WIN_CYCLES+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bouncy_in | input | 1 | Raw asynchronous contact line |
| clean_out | output | 1 | Debounced level |

## Verification
A corrupted window counter shows up at the ports as a shifted output edge. For a clean step, `clean_out` moves earlier or later than edge n+WIN_CYCLES+2, so a fault of one cycle is visible on the first step.

A machine that leaves `ST_HOLD` early, or re-arms on its own, lets a short pulse through, or passes an extra edge, within one window length. A synchroniser or previous-level fault either misses a change entirely or re-triggers a window after a settled pattern. Either effect shows a window length later.

The bench sweeps every bounce pattern inside the window and every pulse width up to twice the window. It compares each cycle of `clean_out` against the edge count worked out from these rules.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    // Debouncer control states
    typedef enum logic {
        ST_IDLE = 1'b0,   // waiting for a change on the synchronised line
        ST_HOLD = 1'b1    // lockout window running
    } dbn_state_t;

endpackage

// File: rtl/dbn_sync.sv
// Multi-stage synchroniser plus previous-level register and change flag.
module dbn_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic toggled
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES < 2) begin : g_bad_depth
            initial $error("dbn_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            prev_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign level   = chain_q[SYNC_STAGES-1];
    assign toggled = chain_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/dbn_window.sv
// Lockout window counter: runs while enabled, flags its final cycle.
module dbn_window #(
    parameter int WIN_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);

    localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/lockout_debouncer.sv
// Lockout-window debouncer: synchroniser, change detect, fixed window.
module lockout_debouncer #(
    parameter int WIN_CYCLES  = 25000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bouncy_in,
    output logic clean_out
);
    import dbn_pkg::*;

    logic       sync_lvl;
    logic       sync_chg;
    logic       win_last;
    logic       in_hold;
    dbn_state_t state_q;
    dbn_state_t state_d;

    dbn_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (bouncy_in),
        .level    (sync_lvl),
        .toggled  (sync_chg)
    );

    dbn_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
        .clk  (clk),
        .rst  (rst),
        .run  (in_hold),
        .last (win_last)
    );

    assign in_hold = (state_q == ST_HOLD);

    // Next state: arm on a change, release at the window's last cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sync_chg) state_d = ST_HOLD;   // arm
            ST_HOLD: if (win_last) state_d = ST_IDLE;   // release
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output register: updated only on release
    always_ff @(posedge clk) begin
        if (rst) begin
            clean_out <= 1'b0;
        end else if (in_hold && win_last) begin
            clean_out <= sync_lvl;
        end
    end

endmodule

// File: rtl/dbn_checker.sv
// Assertion checker for lockout_debouncer, attached by bind below.
module dbn_checker #(
    parameter int WIN_CYCLES = 25000
) (
    input logic clk,
    input logic rst,
    input logic clean_out,
    input logic sync_lvl,
    input logic in_hold,
    input logic win_last
);
    localparam int GAP_W = $clog2(WIN_CYCLES + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(WIN_CYCLES + 1);

    logic             prev_out_q;
    logic [GAP_W-1:0] gap_q;
    logic             out_chg;

    assign out_chg = clean_out ^ prev_out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_out_q <= 1'b0;
            gap_q      <= GAP_MIN;
        end else begin
            prev_out_q <= clean_out;
            if (out_chg)              gap_q <= GAP_W'(1);
            else if (gap_q < GAP_MIN) gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !clean_out);

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (in_hold && !win_last) |=> $stable(clean_out));

    a_r4_takes_sync: assert property (@(posedge clk) disable iff (rst)
        (in_hold && win_last) |=> (clean_out == $past(sync_lvl)));

    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !in_hold |=> $stable(clean_out));

    a_r6_change_spacing: assert property (@(posedge clk) disable iff (rst)
        out_chg |-> (gap_q >= GAP_MIN));

endmodule

bind lockout_debouncer dbn_checker #(.WIN_CYCLES(WIN_CYCLES)) i_dbn_checker (
    .clk       (clk),
    .rst       (rst),
    .clean_out (clean_out),
    .sync_lvl  (sync_lvl),
    .in_hold   (in_hold),
    .win_last  (win_last)
);

// File: tb/test_lockout_debouncer.sv
module test_lockout_debouncer;

    localparam int WIN = 8;
    localparam int LAT = WIN + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bouncy_in = 1'b0;
    logic clean_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    lockout_debouncer #(.WIN_CYCLES(WIN)) i_lockout_debouncer (
        .clk       (clk),
        .rst       (rst),
        .bouncy_in (bouncy_in),
        .clean_out (clean_out)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: clean_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Drive one input value for the next edge, then sample after that edge.
    task automatic cycle(logic v);
        bouncy_in = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Single pulse of w cycles away from base (R2, R4, R5, R6)
    task automatic run_pulse(logic base, int w);
        for (int j = 0; j <= w + WIN + 10; j++) begin
            logic v;
            logic e;
            v = (j < w) ? ~base : base;
            e = (w > WIN && j >= LAT && j < w + LAT) ? ~base : base;
            cycle(v);
            if (w > WIN) check("R5 R6 pulse", clean_out, e);
            else         check("R2 R4 short pulse", clean_out, e);
        end
    endtask

    // Opening edge, bounce pattern inside the window, then settle (R3, R4)
    task automatic run_bounce(logic base, int mask, logic fin);
        for (int j = 0; j <= LAT + 10; j++) begin
            logic v;
            logic e;
            if (j == 0)       v = ~base;
            else if (j < WIN) v = logic'((mask >> (j - 1)) & 1);
            else              v = fin;
            e = (j < LAT) ? base : fin;
            cycle(v);
            check("R3 R4 bounce", clean_out, e);
        end
    endtask

    initial begin
        logic cur;
        @(negedge clk);
        repeat (4) @(negedge clk);
        check("R1 during reset", clean_out, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0);
            check("R1 idle low after reset", clean_out, 1'b0);
        end
        // Pulse widths from base 0
        for (int w = 1; w <= 2 * WIN + 2; w++) run_pulse(1'b0, w);
        // Clean step to 1 (R2 exact latency)
        for (int j = 0; j <= LAT + 4; j++) begin
            cycle(1'b1);
            check("R2 step latency", clean_out, (j >= LAT) ? 1'b1 : 1'b0);
        end
        // Pulse widths from base 1
        for (int w = 1; w <= 2 * WIN + 2; w++) run_pulse(1'b1, w);
        // Every bounce pattern inside the window, both settle levels
        cur = 1'b1;
        for (int m = 0; m < (1 << (WIN - 1)); m++) begin
            for (int f = 0; f < 2; f++) begin
                run_bounce(cur, m, logic'(f));
                cur = logic'(f);
            end
        end
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

endmodule